// File: doc/BRIEF.md
# Byte-Wide Memory Access Controller with Power-Fail Lockout

This block is the control front end of a byte-wide static memory, written as a synchronous design. Each cycle it decodes three active-low strobes into one of four access modes: chip select, read-output gate and write strobe. It also drives the enable of the data bus tri-state buffer and issues a single-cycle commit pulse when a write completes. The memory array itself lies outside the block and uses that pulse to store the byte.

A raw power-good level from an external supply comparator passes through a synchronizer. While it reads low, the block forces the chip select inactive, so no read or write can occur, and it holds an active-low power-fail flag low. When the supply returns, a recovery counter keeps accesses blocked for a set number of clock cycles. A write that is in progress when the supply drops is discarded. A write strobe still held low across the whole outage cannot start a new write until it has been released.

The block has no streaming data path. Every pin is a plain level signal, so no valid/ready handshake applies and no back-pressure rules exist.

Top module: `bytewide_access_ctl`

## Requirements
- R1: With `sel_n` high the mode is idle (code 0) and `bus_drive` is 0, whatever `rd_gate_n` and `wr_strobe_n` are.
- R2: With `sel_n` low, `wr_strobe_n` high and `rd_gate_n` low, the mode is read-driving (code 2) and `bus_drive` is 1.
- R3: With `sel_n` low, `wr_strobe_n` high and `rd_gate_n` high, the mode is read with the bus undriven (code 1) and `bus_drive` is 0.
- R4: With `sel_n` and `wr_strobe_n` both low, the mode is write (code 3) and `bus_drive` is 0 for either level of `rd_gate_n`. This includes the cycle in which the write strobe falls while the read gate is already low.
- R5: When the mode leaves write, `wr_commit` is 1 for exactly one cycle. That cycle is the one after the first clock edge at which the mode is no longer write.
- R6: `pfail_n` follows `pwr_good_in` through a two-stage synchronizer: it changes after the second clock edge following a change of the input, and it is 0 out of reset.
- R7: While `pfail_n` is 0, and for `RECOV_CYCLES` further clock edges after it rises, the mode is idle and `bus_drive` is 0 for all strobe patterns.
- R8: A write in progress when the lockout begins produces no `wr_commit`. If `sel_n` and `wr_strobe_n` stay low through the lockout, the mode stays idle until one of them has gone high. A later fresh write then commits normally.
- R9: After reset the block is locked out: the mode is idle and `wr_commit` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_n | input | 1 | Active-low chip select |
| rd_gate_n | input | 1 | Active-low read output gate |
| wr_strobe_n | input | 1 | Active-low write strobe |
| pwr_good_in | input | 1 | Raw supply-in-tolerance level, asynchronous |
| access_mode | output | 2 | 0 idle, 1 read undriven, 2 read driving, 3 write |
| bus_drive | output | 1 | Enable for the data bus output buffer |
| wr_commit | output | 1 | One-cycle pulse that stores the pending byte |
| pfail_n | output | 1 | Active-low power-fail flag |

## Verification
The assertions assume that the three strobes are already synchronous to `clk`, and that only `pwr_good_in` arrives asynchronously. They also assume that each power-good level lasts well beyond the synchronizer depth. The stimulus meets both assumptions: it changes every input shortly after a rising edge, and it holds each power level for tens of cycles. Random strobe patterns are applied only while the supply is good and the recovery interval has ended. Outages and recoveries are driven as directed sequences with counted edges.

// File: rtl/bytewide_access_pkg.sv
package bytewide_access_pkg;
  typedef enum logic [1:0] {
    MODE_IDLE   = 2'd0,
    MODE_RD_HIZ = 2'd1,
    MODE_RD     = 2'd2,
    MODE_WR     = 2'd3
  } access_mode_t;
endpackage

// File: rtl/bwa_pwr_guard.sv
module bwa_pwr_guard #(
  parameter int SYNC_STAGES  = 2,
  parameter int RECOV_CYCLES = 2_500_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pg_raw,
  output logic pg_ok,
  output logic lockout
);
  localparam int CNT_W = $clog2(RECOV_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(RECOV_CYCLES);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CNT_W-1:0]       recov_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], pg_raw};
  end

  assign pg_ok = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rst_n || !pg_ok)      recov_cnt <= '0;
    else if (recov_cnt != CNT_MAX) recov_cnt <= recov_cnt + 1'b1;
  end

  assign lockout = !pg_ok || (recov_cnt != CNT_MAX);

  // R7
  cnt_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    recov_cnt <= CNT_MAX);
  // R7
  cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pg_ok |=> recov_cnt == '0);
endmodule

// File: rtl/bwa_mode_decode.sv
module bwa_mode_decode
  import bytewide_access_pkg::*;
(
  input  logic         sel_n,
  input  logic         rd_gate_n,
  input  logic         wr_strobe_n,
  input  logic         inhibit,
  input  logic         wr_hold,
  output access_mode_t mode
);
  always_comb begin
    if (sel_n || inhibit)   mode = MODE_IDLE;
    else if (!wr_strobe_n)  mode = wr_hold ? MODE_IDLE : MODE_WR;
    else if (!rd_gate_n)    mode = MODE_RD;
    else                    mode = MODE_RD_HIZ;
  end
endmodule

// File: rtl/bwa_write_track.sv
module bwa_write_track
  import bytewide_access_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sel_n,
  input  logic         wr_strobe_n,
  input  logic         lockout,
  input  access_mode_t mode,
  output logic         wr_hold,
  output logic         commit
);
  logic active_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_hold  <= 1'b0;
      active_q <= 1'b0;
      commit   <= 1'b0;
    end else begin
      wr_hold  <= !sel_n && !wr_strobe_n && (lockout || wr_hold);
      active_q <= (mode == MODE_WR);
      commit   <= active_q && (mode != MODE_WR) && !lockout;
    end
  end

  // R5
  commit_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !commit);
  // R8
  lockout_no_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lockout |=> !commit);
  // R8
  hold_blocks_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hold |-> mode != MODE_WR);
endmodule

// File: rtl/bytewide_access_ctl.sv
module bytewide_access_ctl
  import bytewide_access_pkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int RECOV_CYCLES = 2_500_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel_n,
  input  logic       rd_gate_n,
  input  logic       wr_strobe_n,
  input  logic       pwr_good_in,
  output logic [1:0] access_mode,
  output logic       bus_drive,
  output logic       wr_commit,
  output logic       pfail_n
);
  logic         pg_ok;
  logic         lockout;
  logic         wr_hold;
  access_mode_t mode;

  bwa_pwr_guard #(.SYNC_STAGES(SYNC_STAGES), .RECOV_CYCLES(RECOV_CYCLES)) u_guard (
    .clk(clk), .rst_n(rst_n), .pg_raw(pwr_good_in), .pg_ok(pg_ok), .lockout(lockout)
  );

  bwa_mode_decode u_decode (
    .sel_n(sel_n), .rd_gate_n(rd_gate_n), .wr_strobe_n(wr_strobe_n),
    .inhibit(lockout), .wr_hold(wr_hold), .mode(mode)
  );

  bwa_write_track u_track (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .wr_strobe_n(wr_strobe_n),
    .lockout(lockout), .mode(mode), .wr_hold(wr_hold), .commit(wr_commit)
  );

  assign access_mode = mode;
  assign bus_drive   = (mode == MODE_RD);
  assign pfail_n     = pg_ok;

  // R7
  lockout_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lockout |-> (access_mode == 2'd0 && !bus_drive));
  // R2
  drive_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_drive |-> (!sel_n && !rd_gate_n && wr_strobe_n));
  // R4
  write_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_strobe_n |-> !bus_drive);
  // R6
  pfail_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pfail_n |-> lockout);
endmodule

// File: tb/bytewide_access_ctl_test.sv
module bytewide_access_ctl_test;
  localparam int RECOV = 20;

  logic clk = 1'b0;
  logic rst_n, sel_n, rd_gate_n, wr_strobe_n, pwr_good_in;
  logic [1:0] access_mode;
  logic bus_drive, wr_commit, pfail_n;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  bytewide_access_ctl #(.SYNC_STAGES(2), .RECOV_CYCLES(RECOV)) uut (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .rd_gate_n(rd_gate_n),
    .wr_strobe_n(wr_strobe_n), .pwr_good_in(pwr_good_in),
    .access_mode(access_mode), .bus_drive(bus_drive),
    .wr_commit(wr_commit), .pfail_n(pfail_n)
  );

  function automatic int exp_mode(logic s, logic o, logic w);
    if (s) return 0;
    if (!w) return 3;
    if (!o) return 2;
    return 1;
  endfunction

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic drive(logic s, logic o, logic w);
    sel_n = s; rd_gate_n = o; wr_strobe_n = w;
    #1;
  endtask

  task automatic chk_mode(string req, logic s, logic o, logic w);
    chk(req, int'(access_mode), exp_mode(s, o, w));
    chk(req, int'(bus_drive), int'(exp_mode(s, o, w) == 2));
  endtask

  task automatic power_up_and_wait();
    pwr_good_in = 1'b1;
    repeat (2 + RECOV) tick();
  endtask

  initial begin
    int hist1, hist2, m;
    logic s, o, w;
    rst_n = 1'b0; pwr_good_in = 1'b0;
    sel_n = 1'b1; rd_gate_n = 1'b1; wr_strobe_n = 1'b1;
    repeat (3) tick();
    rst_n = 1'b1;
    drive(0, 0, 1);
    // R9: locked after reset
    chk("R9 mode", int'(access_mode), 0);
    chk("R9 commit", int'(wr_commit), 0);
    chk("R6 reset pfail_n", int'(pfail_n), 0);

    // R6 / R7: power-up timing with a read pending
    tick();
    pwr_good_in = 1'b1;
    tick();
    chk("R6 pfail_n edge1", int'(pfail_n), 0);
    tick();
    chk("R6 pfail_n edge2", int'(pfail_n), 1);
    chk("R7 locked at pfail rise", int'(access_mode), 0);
    repeat (RECOV - 1) tick();
    chk("R7 still locked last cycle", int'(access_mode), 0);
    chk("R7 no drive while locked", int'(bus_drive), 0);
    tick();
    chk_mode("R2 read after recovery", 0, 0, 1);

    // R1, R3, R4 directed
    drive(1, 0, 0); chk_mode("R1 deselect", 1, 0, 0);
    tick(); drive(0, 1, 1); chk_mode("R3 read hiz", 0, 1, 1);
    tick(); drive(0, 0, 1); chk_mode("R2 read drive", 0, 0, 1);
    tick(); drive(0, 0, 0); chk_mode("R4 write with gate low", 0, 0, 0);
    tick(); drive(0, 1, 0); chk_mode("R4 write with gate high", 0, 1, 0);

    // R5: commit pulse timing
    tick(); drive(0, 1, 1);
    chk("R5 no commit before edge", int'(wr_commit), 0);
    tick(); chk("R5 commit pulse", int'(wr_commit), 1);
    tick(); chk("R5 commit one cycle", int'(wr_commit), 0);

    // R8: abort on power loss mid-write
    drive(0, 1, 0);
    tick();
    pwr_good_in = 1'b0;
    tick();
    chk("R8 write before sync", int'(access_mode), 3);
    tick();
    chk("R6 pfail_n falls", int'(pfail_n), 0);
    chk("R7 idle on power loss", int'(access_mode), 0);
    for (int i = 0; i < 5; i++) begin
      tick();
      chk("R8 no commit on abort", int'(wr_commit), 0);
    end
    power_up_and_wait();
    chk("R8 held strobe stays idle", int'(access_mode), 0);
    chk("R8 no commit after recovery", int'(wr_commit), 0);
    drive(0, 1, 1);
    chk_mode("R8 release gives read", 0, 1, 1);
    tick(); tick();
    chk("R8 release no commit", int'(wr_commit), 0);
    drive(0, 1, 0);
    chk_mode("R8 fresh write", 0, 1, 0);
    tick(); drive(0, 1, 1);
    tick(); chk("R8 fresh write commits", int'(wr_commit), 1);

    // idle to prime history
    drive(1, 1, 1);
    tick(); tick();
    hist1 = 0; hist2 = 0;

    // R1-R5 random
    void'($urandom(32'd2024));
    for (int n = 0; n < 400; n++) begin
      tick();
      chk("R5 random commit", int'(wr_commit), int'(hist2 == 3 && hist1 != 3));
      s = ($urandom % 4) == 0;
      o = $urandom % 2;
      w = ($urandom % 3) != 0;
      drive(s, o, w);
      m = exp_mode(s, o, w);
      chk_mode("R1-4 random mode", s, o, w);
      hist2 = hist1;
      hist1 = m;
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule